// File: doc/BRIEF.md
# Dual-Bank RGB Gain Register File

This block keeps the byte-wide configuration registers of an optical power monitor front end and turns them into the settings the analog chain uses. A serial-slave framer, which lies outside this block, drives a simple register bus: a write strobe, a read strobe, a 7-bit address and a data byte. Reads return a byte one cycle after the strobe. Three addresses return fixed identification codes. One register holds a device-select byte that the framer uses for addressing.

Each of three colours (red, green, blue) has two 12-bit fine-gain words, one for a high-gain bank and one for a low-gain bank. The high bank is chosen only when an external bank pin and a control bit are both 1. This allows fast bank switching from the pin or switching from software. A colour mode picks which colour's words, and which slow-tail register, drive the outputs. Blue mode takes priority over the red/green choice. The block also outputs the 2-bit transimpedance gain code of the active bank, the slow-tail settings, a sleep flag, and the deglitch and test enables.

Top module: `rgb_gain_regfile`

## Requirements
- R1: A read of address 00h returns 28h, 01h returns E0h and 02h returns 00h. Writes to these three addresses do not change what they return.
- R2: Address 03h is a read/write device-select byte with reset value 43h, and it is driven on `dev_select`.
- R3: After reset, the upper-gain registers (12h, 13h, 15h, 16h, 18h, 19h) read 7Fh. The nibble registers (11h, 14h, 17h) read FFh. The control register (10h), the slow-tail registers (1Ah, 1Bh, 1Eh) and the gain-code register (1Ch) read 00h.
- R4: The effective bank is high only when `bank_pin` is 1 and control bit 7 is 1. In every other case it is low.
- R5: Colour selection uses two control bits. When bit 5 is 1, blue is selected whatever bit 4 holds. Otherwise bit 4 selects red (1) or green (0).
- R6: A colour's gain word is built from three registers. The high-bank word takes bits 11:4 from the colour's high register and bits 3:0 from bits 7:4 of its nibble register. The low-bank word takes bits 11:4 from the colour's low register and bits 3:0 from bits 3:0 of the nibble register. The nibble/high/low addresses are 11h/12h/13h for blue, 14h/15h/16h for red and 17h/18h/19h for green.
- R7: A slow-tail register stores an enable in bit 7, a time field in bits 6:4 and a magnitude field in bits 2:0. Bit 3 always reads 0. When a write puts 0 in the enable bit, both fields are stored as 000b.
- R8: The slow-tail outputs come from the register of the selected colour: 1Ah for red, 1Bh for green and 1Eh for blue.
- R9: Register 1Ch holds the high-bank code in bits 3:2 and the low-bank code in bits 1:0, and bits 7:4 read 0. `tia_code` outputs the code of the effective bank (00b is the lowest gain, 11b the highest).
- R10: Reads of any address other than 00h-03h, 10h-1Ch and 1Eh return 00h, and writes to those addresses change no register or output.
- R11: `sleep` is the inverse of control bit 0, `deglitch_en` follows control bit 6 and `test_en` follows control bit 3. While `sleep` is 1, all registers can still be written and read.
- R12: `bus_rdata` updates on the clock edge that samples `bus_rd`. The derived outputs update on the edge after the register write or the `bank_pin` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| bank_pin | input | 1 | External bank-select pin (1 = high bank allowed) |
| gain_word | output | 12 | Active fine-gain word |
| tia_code | output | 2 | Active transimpedance gain code |
| st_enable | output | 1 | Active slow-tail enable |
| st_time | output | 3 | Active slow-tail time field |
| st_mag | output | 3 | Active slow-tail magnitude field |
| sleep | output | 1 | Sleep request to the analog blocks |
| deglitch_en | output | 1 | Serial deglitch enable |
| test_en | output | 1 | Test function enable |
| dev_select | output | 8 | Device-select byte |

## Verification
The bench drives the pin and the control bit through all four combinations. A design that used OR, or the pin alone, in place of AND would switch banks in the wrong cases. It sets blue mode with the red/green bit both 0 and 1, which catches a priority inverted between the two bits. It writes distinct values to the two nibble halves and the upper bytes, so a swapped nibble or bank shows up in the gain word. It also writes slow-tail bytes with the enable clear and nonzero fields, writes the identification and unused addresses, and accesses registers while sleep is set. A design that stored such writes, or locked the registers during sleep, would fail these reads.

// File: rtl/rgbg_pkg.sv
package rgbg_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = 4;
  localparam int GAIN_W = DATA_W + NIB_W;
  localparam int IDX_W  = 5;
  localparam int NREG   = 1 << IDX_W;

  localparam logic [IDX_W-1:0] A_ID0  = 5'h00;
  localparam logic [IDX_W-1:0] A_ID1  = 5'h01;
  localparam logic [IDX_W-1:0] A_ID2  = 5'h02;
  localparam logic [IDX_W-1:0] A_DSEL = 5'h03;
  localparam logic [IDX_W-1:0] A_CTRL = 5'h10;
  localparam logic [IDX_W-1:0] A_TIA  = 5'h1C;

  localparam logic [DATA_W-1:0] ID0_VAL = 8'h28;
  localparam logic [DATA_W-1:0] ID1_VAL = 8'hE0;
  localparam logic [DATA_W-1:0] ID2_VAL = 8'h00;

  typedef enum logic [1:0] {COL_BLUE = 2'd0, COL_RED = 2'd1, COL_GREEN = 2'd2} colour_t;

  // nibble register of a colour; high and low uppers follow at +1 and +2
  function automatic logic [IDX_W-1:0] gain_base(input int c);
    return IDX_W'(5'h11 + 3 * c);
  endfunction

  function automatic logic [IDX_W-1:0] st_addr(input int c);
    case (c)
      0:       return 5'h1E;
      1:       return 5'h1A;
      default: return 5'h1B;
    endcase
  endfunction

  function automatic bit is_writable(input logic [IDX_W-1:0] i);
    return (i == A_DSEL) || (i >= 5'h10 && i <= 5'h1C) || (i == 5'h1E);
  endfunction

  function automatic bit is_st(input logic [IDX_W-1:0] i);
    return (i == 5'h1A) || (i == 5'h1B) || (i == 5'h1E);
  endfunction

  function automatic bit is_nibble(input logic [IDX_W-1:0] i);
    return (i == 5'h11) || (i == 5'h14) || (i == 5'h17);
  endfunction

  function automatic bit is_upper(input logic [IDX_W-1:0] i);
    return (i >= 5'h11 && i <= 5'h19) && !is_nibble(i);
  endfunction

  function automatic logic [DATA_W-1:0] reset_val(input logic [IDX_W-1:0] i);
    if (i == A_DSEL)   return 8'h43;
    if (is_nibble(i))  return 8'hFF;
    if (is_upper(i))   return 8'h7F;
    return 8'h00;
  endfunction

  // shapes a write byte into what the register keeps
  function automatic logic [DATA_W-1:0] store_val(input logic [IDX_W-1:0] i,
                                                  input logic [DATA_W-1:0] d);
    if (is_st(i))   return d[7] ? {1'b1, d[6:4], 1'b0, d[2:0]} : 8'h00;
    if (i == A_TIA) return {4'h0, d[3:0]};
    return d;
  endfunction
endpackage

// File: rtl/rgbg_regs.sv
module rgbg_regs
  import rgbg_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic [NREG*DATA_W-1:0] reg_flat
);
  localparam int HI_W = ADDR_W - IDX_W;

  logic [DATA_W-1:0] regs_q [NREG];
  logic [IDX_W-1:0]  idx;
  logic              in_range;
  logic [DATA_W-1:0] rd_val;

  assign idx      = bus_addr[IDX_W-1:0];
  assign in_range = (bus_addr[ADDR_W-1:IDX_W] == HI_W'(0));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= reset_val(IDX_W'(i));
    end else if (bus_wr && in_range && is_writable(idx)) begin
      regs_q[idx] <= store_val(idx, bus_wdata);
    end
  end

  always_comb begin
    rd_val = '0;
    if (in_range) begin
      case (idx)
        A_ID0:   rd_val = ID0_VAL;
        A_ID1:   rd_val = ID1_VAL;
        A_ID2:   rd_val = ID2_VAL;
        default: rd_val = is_writable(idx) ? regs_q[idx] : '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign reg_flat[g*DATA_W +: DATA_W] = regs_q[g];
  end

  assert_id0_read_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(0)) |=> bus_rdata == 8'h28);
  assert_unused_read_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(7'h1D)) |=> bus_rdata == 8'h00);
  assert_read_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/rgbg_select.sv
module rgbg_select
  import rgbg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bank_pin,
  input  logic [NREG*DATA_W-1:0] reg_flat,
  output logic [GAIN_W-1:0]      gain_word,
  output logic [1:0]             tia_code,
  output logic                   st_enable,
  output logic [2:0]             st_time,
  output logic [2:0]             st_mag,
  output logic                   sleep,
  output logic                   deglitch_en,
  output logic                   test_en,
  output logic [DATA_W-1:0]      dev_select
);
  localparam int NCOL = 3;

  logic [DATA_W-1:0] ctrl, tia_r;
  logic [GAIN_W-1:0] word_hi [NCOL];
  logic [GAIN_W-1:0] word_lo [NCOL];
  logic [DATA_W-1:0] st_r    [NCOL];
  logic              bank_hi;
  colour_t           col;

  assign ctrl  = reg_flat[A_CTRL*DATA_W +: DATA_W];
  assign tia_r = reg_flat[A_TIA*DATA_W +: DATA_W];

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    localparam int NB = int'(gain_base(c));
    localparam int SA = int'(st_addr(c));
    logic [DATA_W-1:0] nib, up_hi, up_lo;
    assign nib        = reg_flat[NB*DATA_W +: DATA_W];
    assign up_hi      = reg_flat[(NB+1)*DATA_W +: DATA_W];
    assign up_lo      = reg_flat[(NB+2)*DATA_W +: DATA_W];
    assign word_hi[c] = {up_hi, nib[7:4]};
    assign word_lo[c] = {up_lo, nib[3:0]};
    assign st_r[c]    = reg_flat[SA*DATA_W +: DATA_W];
  end

  assign bank_hi = bank_pin & ctrl[7];

  always_comb begin
    if (ctrl[5])      col = COL_BLUE;
    else if (ctrl[4]) col = COL_RED;
    else              col = COL_GREEN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_word   <= '0;
      tia_code    <= '0;
      st_enable   <= 1'b0;
      st_time     <= '0;
      st_mag      <= '0;
      sleep       <= 1'b1;
      deglitch_en <= 1'b0;
      test_en     <= 1'b0;
      dev_select  <= '0;
    end else begin
      gain_word   <= bank_hi ? word_hi[col] : word_lo[col];
      tia_code    <= bank_hi ? tia_r[3:2] : tia_r[1:0];
      st_enable   <= st_r[col][7];
      st_time     <= st_r[col][6:4];
      st_mag      <= st_r[col][2:0];
      sleep       <= ~ctrl[0];
      deglitch_en <= ctrl[6];
      test_en     <= ctrl[3];
      dev_select  <= reg_flat[A_DSEL*DATA_W +: DATA_W];
    end
  end

  assert_st_fields_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !st_enable |-> (st_time == 3'd0 && st_mag == 3'd0));
  assert_sleep_follows_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sleep == !$past(ctrl[0]));
  assert_pin_low_bank_R4: assert property (@(posedge clk) disable iff (rst)
    !bank_pin |=> tia_code == $past(tia_r[1:0]));
  assert_blue_gain_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl[5] && !bank_hi) |=> gain_word == $past(word_lo[0]));
endmodule

// File: rtl/rgb_gain_regfile.sv
module rgb_gain_regfile
  import rgbg_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              bank_pin,
  output logic [11:0]       gain_word,
  output logic [1:0]        tia_code,
  output logic              st_enable,
  output logic [2:0]        st_time,
  output logic [2:0]        st_mag,
  output logic              sleep,
  output logic              deglitch_en,
  output logic              test_en,
  output logic [7:0]        dev_select
);
  logic [NREG*DATA_W-1:0] reg_flat;

  rgbg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .reg_flat  (reg_flat)
  );

  rgbg_select u_sel (
    .clk         (clk),
    .rst         (rst),
    .bank_pin    (bank_pin),
    .reg_flat    (reg_flat),
    .gain_word   (gain_word),
    .tia_code    (tia_code),
    .st_enable   (st_enable),
    .st_time     (st_time),
    .st_mag      (st_mag),
    .sleep       (sleep),
    .deglitch_en (deglitch_en),
    .test_en     (test_en),
    .dev_select  (dev_select)
  );
endmodule

// File: tb/rgb_gain_regfile_bench.sv
module rgb_gain_regfile_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bank_pin = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, dev_select;
  logic [11:0] gain_word;
  logic [1:0] tia_code;
  logic st_enable, sleep, deglitch_en, test_en;
  logic [2:0] st_time, st_mag;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rgb_gain_regfile u_rgb_gain_regfile (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bank_pin(bank_pin),
    .gain_word(gain_word), .tia_code(tia_code), .st_enable(st_enable),
    .st_time(st_time), .st_mag(st_mag), .sleep(sleep), .deglitch_en(deglitch_en),
    .test_en(test_en), .dev_select(dev_select)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // write, then wait until the derived outputs have taken it
  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a, input logic [7:0] exp);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    chk(req, $sformatf("read %02h", a), int'(bus_rdata), int'(exp));
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); bank_pin = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R3", "gain after reset", int'(gain_word), 'h7FF);
    chk("R3", "tia after reset", int'(tia_code), 0);
    chk("R3", "st after reset", int'({st_enable, st_time, st_mag}), 0);
    chk("R11", "sleep after reset", int'(sleep), 1);
    chk("R2", "dev_select reset", int'(dev_select), 'h43);
    rd_chk("R2", 7'h03, 8'h43);
    rd_chk("R3", 7'h10, 8'h00);
    rd_chk("R3", 7'h11, 8'hFF);
    rd_chk("R3", 7'h16, 8'h7F);
    rd_chk("R3", 7'h1C, 8'h00);
    rd_chk("R3", 7'h1E, 8'h00);
  endtask

  task automatic t_ids();
    rd_chk("R1", 7'h00, 8'h28);
    rd_chk("R1", 7'h01, 8'hE0);
    rd_chk("R1", 7'h02, 8'h00);
    wr(7'h00, 8'h55); wr(7'h01, 8'h12); wr(7'h02, 8'h9C);
    rd_chk("R1", 7'h00, 8'h28);
    rd_chk("R1", 7'h01, 8'hE0);
    rd_chk("R1", 7'h02, 8'h00);
  endtask

  task automatic t_unused();
    wr(7'h05, 8'hAA); wr(7'h1D, 8'h3C); wr(7'h31, 8'h00);
    rd_chk("R10", 7'h05, 8'h00);
    rd_chk("R10", 7'h1D, 8'h00);
    rd_chk("R10", 7'h31, 8'h00);
    rd_chk("R10", 7'h11, 8'hFF);
    chk("R10", "gain untouched", int'(gain_word), 'h7FF);
  endtask

  task automatic t_compose();
    wr(7'h17, 8'hA5); wr(7'h18, 8'h12); wr(7'h19, 8'h34);
    chk("R6", "green low word", int'(gain_word), 'h345);
    set_pin(1'b1);
    wr(7'h10, 8'h80);
    chk("R6", "green high word", int'(gain_word), 'h12A);
  endtask

  task automatic t_bank();
    set_pin(1'b0);
    chk("R4", "pin0 bit1 low bank", int'(gain_word), 'h345);
    set_pin(1'b1);
    chk("R12", "pin rise takes one edge", int'(gain_word), 'h12A);
    wr(7'h10, 8'h00);
    chk("R4", "pin1 bit0 low bank", int'(gain_word), 'h345);
    set_pin(1'b0);
    chk("R4", "pin0 bit0 low bank", int'(gain_word), 'h345);
  endtask

  task automatic t_colour();
    wr(7'h14, 8'h6C); wr(7'h15, 8'hAB); wr(7'h16, 8'hCD);
    wr(7'h11, 8'hE3); wr(7'h12, 8'h77); wr(7'h13, 8'h88);
    wr(7'h10, 8'h10);
    chk("R5", "red low", int'(gain_word), 'hCDC);
    wr(7'h10, 8'h30);
    chk("R5", "blue over red", int'(gain_word), 'h883);
    wr(7'h10, 8'h20);
    chk("R5", "blue over green", int'(gain_word), 'h883);
    set_pin(1'b1);
    wr(7'h10, 8'hB0);
    chk("R6", "blue high", int'(gain_word), 'h77E);
    wr(7'h10, 8'h90);
    chk("R6", "red high", int'(gain_word), 'hAB6);
    set_pin(1'b0);
  endtask

  task automatic t_slowtail();
    wr(7'h1A, 8'hD5);
    rd_chk("R7", 7'h1A, 8'hD5);
    wr(7'h1A, 8'h4D);
    rd_chk("R7", 7'h1A, 8'h00);
    wr(7'h1B, 8'hFF);
    rd_chk("R7", 7'h1B, 8'hF7);
    wr(7'h10, 8'h10);
    chk("R7", "red st disabled", int'({st_enable, st_time, st_mag}), 0);
    wr(7'h1A, 8'hA6);
    chk("R8", "red st", int'({st_enable, st_time, st_mag}), 'h56);
    wr(7'h10, 8'h00);
    chk("R8", "green st", int'({st_enable, st_time, st_mag}), 'h7F);
    wr(7'h1E, 8'h93);
    wr(7'h10, 8'h30);
    chk("R8", "blue st", int'({st_enable, st_time, st_mag}), 'h4B);
  endtask

  task automatic t_tia();
    wr(7'h1C, 8'hF6);
    rd_chk("R9", 7'h1C, 8'h06);
    wr(7'h10, 8'h00);
    chk("R9", "low bank code", int'(tia_code), 2);
    set_pin(1'b1);
    wr(7'h10, 8'h80);
    chk("R9", "high bank code", int'(tia_code), 1);
    set_pin(1'b0);
    chk("R4", "pin low picks low code", int'(tia_code), 2);
  endtask

  task automatic t_sleep();
    wr(7'h10, 8'h01);
    chk("R11", "awake", int'({sleep, deglitch_en, test_en}), 0);
    wr(7'h10, 8'h48);
    chk("R11", "sleep+deglitch+test", int'({sleep, deglitch_en, test_en}), 7);
    wr(7'h03, 8'h5A);
    rd_chk("R11", 7'h03, 8'h5A);
    chk("R2", "dev_select written", int'(dev_select), 'h5A);
    wr(7'h18, 8'h01);
    rd_chk("R11", 7'h18, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    t_reset();
    t_ids();
    t_unused();
    t_compose();
    t_bank();
    t_colour();
    t_slowtail();
    t_tia();
    t_sleep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule